// File: doc/BRIEF.md
# Variable Bit Field Extract Unit

This unit takes a bit field of 0 to 32 bits out of a 64-bit window made of two consecutive 32-bit words. The field starts at a signed bit position. The unit can sign-extend or zero-extend the field into a 32-bit result. It can also compare the extended field with a 32-bit operand and produce condition flags. In the same pass it turns a byte base address and the signed position into an aligned word address and a bit offset within that word. It also reports whether the field runs into the following word.

The caller supplies the two window words and asserts `in_valid` for one cycle. For a memory operand the words are the ones at `word_addr` and `word_addr + 4`. For a register operand they are the pair {Rn+1, Rn}. Every output is registered and appears on the cycle after the request, with `out_valid` high. Illegal sizes and illegal register positions raise `rsv_fault` and do not produce a result.

Top module: `bitfield_extract_unit`

## Requirements
- R1: A size of 0 gives the following outputs, with no fault and `need_second` low:
  - `result` is 0.
  - For extract, the flags are N=0, Z=1, V=0 and C=`carry_in`.
  - For compare, the value 0 is compared with `operand`.
- R2: A size above 32 raises `rsv_fault`. While the fault is raised, `result` is 0, all four flags are 0 and `need_second` is low.
- R3: In memory mode (`reg_mode`=0), the byte address is `base_addr` plus the signed position shifted arithmetically right by 3. `word_addr` is that byte address with bits [1:0] cleared. In register mode `word_addr` is 0. Both rules hold whatever the size.
- R4: In memory mode, `bit_off` is pos[2:0] plus 8 times bits [1:0] of the byte address. In register mode, `bit_off` is pos[4:0].
- R5: For a legal size from 1 to 32, `need_second` is high exactly when `bit_off` + size − 1 is greater than 31.
- R6: In register mode, a nonzero size together with a position outside 0..31 raises `rsv_fault`.
- R7: Operation code 00 (signed extract) shifts {`word_hi`,`word_lo`} right by `bit_off`. It keeps the low `size` bits and sign-extends them from bit size−1.
- R8: Operation code 01 (zero extract) selects the same bits as R7 and zero-extends them.
- R9: For extract operations, the flags are set as follows:
  - N is bit 31 of the result.
  - Z is set when the result is zero.
  - V is 0.
  - C equals `carry_in`.
- R10: Operation codes 10 (signed compare) and 11 (zero compare) extend the field as codes 00 and 01 do and place it on `result`. The flags are set as follows:
  - N is signed field < operand.
  - Z is field == operand.
  - C is unsigned field < operand.
  - V is 0.
- R11: After reset, `out_valid` and every output are 0. `out_valid` is high exactly on the cycle after `in_valid`. All other outputs hold their values while no request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; the unit accepts a request in every cycle |
| op | input | 2 | 00 signed extract, 01 zero extract, 10 signed compare, 11 zero compare |
| reg_mode | input | 1 | 1 when the window is a register pair |
| pos | input | 32 | Signed bit position |
| size | input | 8 | Field size in bits |
| base_addr | input | 32 | Byte base address (memory mode) |
| word_lo | input | 32 | Lower window word |
| word_hi | input | 32 | Upper window word |
| operand | input | 32 | Compare operand |
| carry_in | input | 1 | Current C flag, passed through for extract |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| word_addr | output | 32 | Aligned word address |
| bit_off | output | 5 | Bit offset within the first word |
| need_second | output | 1 | The field reaches into the second word |
| result | output | 32 | Extended field |
| flag_n | output | 1 | Negative or less-than flag |
| flag_z | output | 1 | Zero or equal flag |
| flag_v | output | 1 | Overflow flag (always 0) |
| flag_c | output | 1 | Carry or unsigned less-than flag |
| rsv_fault | output | 1 | Reserved-operand fault |

## Verification
On every cycle the assertions check the following:
- The fault rules for oversized fields and for out-of-range register positions.
- The zero-size outcome.
- The one-cycle latency of `out_valid`.
- The spill condition for legal sizes.
- The empty upper bits after a zero extract.
- The carry pass-through and zero flag of extract operations.

Only the bench's sweep can show that the following are numerically correct for each position, lane, size and operation:
- The extracted bits, including their sign extension.
- The word address and bit offset derived from negative positions.
- The three compare flags.

The bench computes its reference values through a separate route: the bit address base*8+pos.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
    parameter int unsigned WORD_W  = 32;
    localparam int unsigned OFF_W  = $clog2(WORD_W);
    localparam int unsigned LANE_W = OFF_W - 3;
    localparam int unsigned SIZE_W = 8;

    typedef enum logic [1:0] {
        OP_SEXT = 2'b00,
        OP_ZEXT = 2'b01,
        OP_SCMP = 2'b10,
        OP_ZCMP = 2'b11
    } bfx_op_e;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] addr;
        logic [OFF_W-1:0]  off;
        logic              span;
        logic [WORD_W-1:0] result;
        logic              n;
        logic              z;
        logic              v;
        logic              c;
        logic              fault;
    } bfx_out_s;
endpackage

// File: rtl/bfx_addr_calc.sv
module bfx_addr_calc
    import bfx_pkg::*;
(
    input  logic [WORD_W-1:0] base_addr,
    input  logic [WORD_W-1:0] pos,
    input  logic              reg_mode,
    output logic [WORD_W-1:0] word_addr,
    output logic [OFF_W-1:0]  bit_off
);
    logic signed [WORD_W-1:0] pos_s;
    logic [WORD_W-1:0]        byte_ofs;
    logic [WORD_W-1:0]        byte_addr;

    always_comb begin
        pos_s     = $signed(pos);
        byte_ofs  = WORD_W'(pos_s >>> 3);
        byte_addr = base_addr + byte_ofs;
        if (reg_mode) begin
            word_addr = '0;
            bit_off   = pos[OFF_W-1:0];
        end else begin
            word_addr = {byte_addr[WORD_W-1:LANE_W], {LANE_W{1'b0}}};
            bit_off   = {byte_addr[LANE_W-1:0], pos[2:0]};
        end
    end

    always_comb begin
        if (!reg_mode) begin
            AST_OFF_LOW_BITS: assert (bit_off[2:0] == pos[2:0]); // R4
        end
    end
endmodule

// File: rtl/bfx_field_shift.sv
module bfx_field_shift
    import bfx_pkg::*;
(
    input  logic [WORD_W-1:0] word_lo,
    input  logic [WORD_W-1:0] word_hi,
    input  logic [OFF_W-1:0]  bit_off,
    input  logic [OFF_W:0]    size,
    input  logic              sign_ext,
    output logic [WORD_W-1:0] field
);
    localparam logic [OFF_W:0] FULL = (OFF_W+1)'(WORD_W);

    logic [2*WORD_W-1:0] window;
    logic [WORD_W-1:0]   raw;
    logic [WORD_W-1:0]   left;
    logic [OFF_W:0]      pad;

    always_comb begin
        window = {word_hi, word_lo} >> bit_off;
        raw    = window[WORD_W-1:0];
        pad    = FULL - size;
        left   = raw << pad;
        if (sign_ext) begin
            field = WORD_W'($signed(left) >>> pad);
        end else begin
            field = left >> pad;
        end
    end
endmodule

// File: rtl/bfx_flag_gen.sv
module bfx_flag_gen
    import bfx_pkg::*;
(
    input  logic [WORD_W-1:0] field,
    input  logic [WORD_W-1:0] operand,
    input  logic              is_cmp,
    input  logic              carry_in,
    output logic              n,
    output logic              z,
    output logic              v,
    output logic              c
);
    always_comb begin
        v = 1'b0;
        if (is_cmp) begin
            n = $signed(field) < $signed(operand);
            z = (field == operand);
            c = (field < operand);
        end else begin
            n = field[WORD_W-1];
            z = (field == '0);
            c = carry_in;
        end
    end
endmodule

// File: rtl/bitfield_extract_unit.sv
module bitfield_extract_unit
    import bfx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [1:0]  op,
    input  logic        reg_mode,
    input  logic [31:0] pos,
    input  logic [7:0]  size,
    input  logic [31:0] base_addr,
    input  logic [31:0] word_lo,
    input  logic [31:0] word_hi,
    input  logic [31:0] operand,
    input  logic        carry_in,
    output logic        out_valid,
    output logic [31:0] word_addr,
    output logic [4:0]  bit_off,
    output logic        need_second,
    output logic [31:0] result,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_v,
    output logic        flag_c,
    output logic        rsv_fault
);
    localparam logic [SIZE_W-1:0] MAX_SIZE = SIZE_W'(WORD_W);

    bfx_out_s          state_d, state_q;
    logic [WORD_W-1:0] addr_w;
    logic [OFF_W-1:0]  off_w;
    logic [WORD_W-1:0] field_w;
    logic              fn_w, fz_w, fv_w, fc_w;
    logic              size_zero, size_big, reg_bad, fault_w, live_w;
    logic [WORD_W-1:0] field_eff;
    logic [OFF_W+1:0]  end_bit;
    bfx_op_e           op_e;

    assign op_e = bfx_op_e'(op);

    bfx_addr_calc u_addr (
        .base_addr (base_addr),
        .pos       (pos),
        .reg_mode  (reg_mode),
        .word_addr (addr_w),
        .bit_off   (off_w)
    );

    bfx_field_shift u_shift (
        .word_lo  (word_lo),
        .word_hi  (word_hi),
        .bit_off  (off_w),
        .size     (size[OFF_W:0]),
        .sign_ext ((op_e == OP_SEXT) || (op_e == OP_SCMP)),
        .field    (field_w)
    );

    always_comb begin
        size_zero = (size == '0);
        size_big  = (size > MAX_SIZE);
        reg_bad   = reg_mode && (pos[WORD_W-1:OFF_W] != '0);
        fault_w   = size_big || (!size_zero && reg_bad);
        live_w    = !size_zero && !fault_w;
        field_eff = live_w ? field_w : '0;
    end

    bfx_flag_gen u_flags (
        .field    (field_eff),
        .operand  (operand),
        .is_cmp   (op[1]),
        .carry_in (carry_in),
        .n        (fn_w),
        .z        (fz_w),
        .v        (fv_w),
        .c        (fc_w)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        end_bit       = (OFF_W+2)'(off_w) + (OFF_W+2)'(size[OFF_W:0]) - 1'b1;
        if (in_valid) begin
            state_d.addr   = addr_w;
            state_d.off    = off_w;
            state_d.span   = live_w && (end_bit > (OFF_W+2)'(WORD_W-1));
            state_d.result = field_eff;
            state_d.fault  = fault_w;
            state_d.n      = fault_w ? 1'b0 : fn_w;
            state_d.z      = fault_w ? 1'b0 : fz_w;
            state_d.v      = fault_w ? 1'b0 : fv_w;
            state_d.c      = fault_w ? 1'b0 : fc_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid   = state_q.valid;
    assign word_addr   = state_q.addr;
    assign bit_off     = state_q.off;
    assign need_second = state_q.span;
    assign result      = state_q.result;
    assign flag_n      = state_q.n;
    assign flag_z      = state_q.z;
    assign flag_v      = state_q.v;
    assign flag_c      = state_q.c;
    assign rsv_fault   = state_q.fault;

    AST_BIG_SIZE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (size > 8'd32) |=> rsv_fault && (result == '0) && !need_second); // R2

    AST_ZERO_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (size == 8'd0) |=> !rsv_fault && (result == '0) && !need_second); // R1

    AST_REG_POS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && reg_mode && (size != 8'd0) && (pos[31:5] != '0) |=> rsv_fault); // R6

    AST_SPAN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !reg_mode && (size != 8'd0) && (size <= 8'd32) |=>
        need_second == ((7'(bit_off) + 7'($past(size)) - 7'd1) > 7'd31)); // R5

    AST_ZEXT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op == 2'b01) && (size != 8'd0) && (size < 8'd32) && !reg_mode |=>
        ((result >> $past(size)) == '0)); // R8

    AST_EXT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !op[1] && (size <= 8'd32) && !reg_mode |=>
        (flag_c == $past(carry_in)) && (flag_z == (result == '0)) && !flag_v); // R9

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid)); // R11
endmodule

// File: tb/bitfield_extract_unit_tb_top.sv
module bitfield_extract_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = '0;
    logic        reg_mode = 1'b0;
    logic [31:0] pos = '0;
    logic [7:0]  size = '0;
    logic [31:0] base_addr = '0;
    logic [31:0] word_lo = '0;
    logic [31:0] word_hi = '0;
    logic [31:0] operand = '0;
    logic        carry_in = 1'b0;
    logic        out_valid, need_second, flag_n, flag_z, flag_v, flag_c, rsv_fault;
    logic [31:0] word_addr, result;
    logic [4:0]  bit_off;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    bitfield_extract_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .reg_mode(reg_mode),
        .pos(pos), .size(size), .base_addr(base_addr), .word_lo(word_lo),
        .word_hi(word_hi), .operand(operand), .carry_in(carry_in),
        .out_valid(out_valid), .word_addr(word_addr), .bit_off(bit_off),
        .need_second(need_second), .result(result), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .rsv_fault(rsv_fault)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h (op=%0d reg=%0b pos=%0d size=%0d)",
                     req, got, exp, op, reg_mode, $signed(pos), size);
        end
    endtask

    function automatic logic [31:0] mix(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // Reference computed from the bit address base*8+pos
    task automatic run_vec();
        logic signed [63:0] bitaddr;
        logic [31:0] e_addr, mask, raw, f, e_res;
        logic [4:0]  e_off;
        logic        e_fault, live, e_span, en, ez, ec;
        logic [63:0] win;
        int          sz;
        sz      = int'(size);
        bitaddr = $signed({32'h0, base_addr}) * 8 + $signed({{32{pos[31]}}, pos});
        if (reg_mode) begin
            e_addr = '0;
            e_off  = pos[4:0];
        end else begin
            e_addr = 32'(bitaddr >>> 5) << 2;
            e_off  = bitaddr[4:0];
        end
        e_fault = (sz > 32) || (reg_mode && sz != 0 && ($signed(pos) < 0 || $signed(pos) > 31));
        live    = (sz != 0) && !e_fault;
        e_span  = live && (int'(e_off) + sz - 1 > 31);
        win     = {word_hi, word_lo} >> e_off;
        raw     = win[31:0];
        mask    = (sz >= 32) ? 32'hFFFF_FFFF : ((32'h1 << sz) - 1);
        f       = raw & mask;
        if (!op[0] && sz > 0 && sz <= 32 && f[sz-1]) f = f | ~mask;
        e_res   = live ? f : 32'h0;
        if (op[1]) begin
            en = $signed(e_res) < $signed(operand);
            ez = e_res == operand;
            ec = e_res < operand;
        end else begin
            en = e_res[31];
            ez = e_res == 0;
            ec = carry_in;
        end
        if (e_fault) begin en = 0; ez = 0; ec = 0; end
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 valid", 64'(out_valid), 64'd1);
        check(reg_mode ? "R3 reg addr" : "R3 addr", 64'(word_addr), 64'(e_addr));
        check("R4 offset", 64'(bit_off), 64'(e_off));
        check(sz > 32 ? "R2 fault" : "R6 fault", 64'(rsv_fault), 64'(e_fault));
        check("R5 span", 64'(need_second), 64'(e_span));
        if (sz == 0)
            check("R1 zero-size result", 64'(result), 64'(e_res));
        else if (op[0])
            check("R8 zext result", 64'(result), 64'(e_res));
        else
            check("R7 sext result", 64'(result), 64'(e_res));
        check(op[1] ? "R10 cmp flags" : "R9 ext flags",
              64'({flag_n, flag_z, flag_v, flag_c}), 64'({en, ez, 1'b0, ec}));
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        logic [31:0] held;
        int mpos[10];
        int rpos[5];
        mpos = '{0, 1, 7, 8, 13, 31, -1, -9, -33, 100};
        rpos = '{0, 5, 31, 32, -1};
        seed = 32'h1234_5679;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset valid", 64'(out_valid), 64'd0);
        check("R11 reset result", 64'({result, word_addr}), 64'd0);
        rst_n = 1'b1;
        for (int o = 0; o < 4; o++) begin
            for (int s = 0; s < 36; s++) begin
                for (int p = 0; p < 10; p++) begin
                    seed      = mix(seed);
                    word_lo   = seed;
                    seed      = mix(seed);
                    word_hi   = seed;
                    seed      = mix(seed);
                    operand   = (p == 3) ? 32'h0 : seed;
                    carry_in  = seed[7];
                    base_addr = 32'h0000_1000 + 32'(p % 4) + 32'(s & 4);
                    op        = 2'(o);
                    size      = (s == 35) ? 8'd255 : 8'(s);
                    pos       = 32'(mpos[p]);
                    reg_mode  = 1'b0;
                    run_vec();
                    if (p < 5) begin
                        reg_mode = 1'b1;
                        pos      = 32'(rpos[p]);
                        run_vec();
                    end
                end
            end
        end
        // Compare with operand equal to the extracted field: Z must be set
        reg_mode = 1'b0; base_addr = 32'h10; pos = 32'd4; size = 8'd8;
        word_lo = 32'h0000_0A50; word_hi = 32'h0; operand = 32'hFFFF_FFA5; op = 2'b10;
        run_vec();
        check("R10 equal Z", 64'(flag_z), 64'd1);
        op = 2'b11; operand = 32'h0000_00A5;
        run_vec();
        check("R10 zext equal Z", 64'(flag_z), 64'd1);
        // Outputs held while idle
        held = result;
        @(negedge clk);
        check("R11 idle valid", 64'(out_valid), 64'd0);
        check("R11 held result", 64'(result), 64'(held));
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule